// File: doc/BRIEF.md
# Shared-Period Toggle PWM Generator

This block drives several PWM pins from one free-running counter. The counter's period is set by a single period compare value. Each channel holds its own pulse compare value. A channel's pin is not made by comparing magnitudes. It flips at the channel's pulse event and flips back at the shared period event. The counter returns to zero at each period event.

Requests arrive on a one-cycle configuration port. A request names a channel and gives a period, a pulse width, a polarity bit and a counter mode. In fixed mode the compare values are stored as given. In adjusted mode the counter clears one tick after the match, so the values are stored minus one. A pulse width of zero, or one equal to the period, gives a steady level and uses no compare events. A request that cannot be honoured raises an error flag for one cycle and changes nothing. When no channel is making a waveform, the counter stops.

Top module: `pwm_toggle_multi`

## Requirements
- R1: Reset drives pin n to bit n of parameter INIT_HIGH (default 4'b0010) and holds cfg_err low; all channels start with no waveform.
- R2: An accepted adjusted-mode request with period P and pulse W (0 < W < P) sets the pin to the active level at the accepting edge. The pin stays active for W cycles and inactive for P-W cycles, and repeats every P cycles.
- R3: In fixed mode (cfg_adjusted = 0) the waveform is the same as in R2. A period above 65535 is rejected in this mode.
- R4: In adjusted mode (cfg_adjusted = 1) a period up to 2^24 is accepted and a larger one is rejected.
- R5: The active level is 1 when cfg_invert = 0 and 0 when cfg_invert = 1; the inactive level is its complement.
- R6: Pulse 0 drives the pin steadily inactive, and pulse equal to the period drives it steadily active. Such requests are never rejected for a period or mode conflict.
- R7: A waveform request is rejected if any other channel is making a waveform with a different period or a different counter mode.
- R8: A request whose channel index is at or above NCH, or whose pulse exceeds its period, is rejected.
- R9: An accepted waveform request clears the shared counter. In the same cycle every other waveform channel restarts at its active level, so all channels stay phase-aligned.
- R10: When a steady-level request leaves no channel making a waveform, the counter stops and every pin holds its steady level.
- R11: cfg_err is high for exactly the cycle after a rejected request and low otherwise. A rejected request leaves all pins and stored settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Request strobe, one cycle |
| cfg_chan | input | CHW (3) | Channel index of the request |
| cfg_period | input | PW (25) | Period in counter ticks |
| cfg_pulse | input | PW (25) | Active width in counter ticks |
| cfg_invert | input | 1 | 1 selects active-low output |
| cfg_adjusted | input | 1 | 1 selects minus-one adjusted counter mode |
| pwm_pin | output | NCH (4) | Channel outputs |
| cfg_err | output | 1 | Rejected-request flag |

## Verification
Outputs are made by toggling, so a missed or extra toggle does not correct itself. It inverts the pin for every later period, and a phase-tracking reference shows the fault within one period. A wrong counter clear or compare encoding moves the pulse edge by one cycle at the first pulse after the request. Per-cycle pin comparison exposes this at once. A decision error in request checking shows on cfg_err in the cycle after the request. If such a request is wrongly accepted, the pins usually disagree with the reference within the next period.

// File: rtl/pwm_toggle_pkg.sv
package pwm_toggle_pkg;
    // decoded outcome of one configuration request
    typedef struct packed {
        logic accept;  // request takes effect
        logic reject;  // request refused, raise error
        logic wave;    // accepted request needs compare events
        logic lvl;     // pin level loaded at acceptance
        logic stop;    // no waveform channel remains afterwards
    } req_dec_t;
endpackage

// File: rtl/pwm_req_check.sv
module pwm_req_check
    import pwm_toggle_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CW      = 24,
    parameter int FIX_MAX = 65535,
    localparam int CHW    = $clog2(NCH) + 1,
    localparam int PW     = CW + 1
) (
    input  logic           cfg_valid,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [PW-1:0]  cfg_period,
    input  logic [PW-1:0]  cfg_pulse,
    input  logic           cfg_invert,
    input  logic           cfg_adjusted,
    input  logic [NCH-1:0] gen_vec,
    input  logic [PW-1:0]  per_q,
    input  logic           mode_q,
    output req_dec_t       dec,
    output logic [CW-1:0]  pul_cmp,
    output logic [CW-1:0]  per_cmp
);
    localparam logic [PW-1:0] ADJ_LIM = PW'(1) << CW;

    logic           chan_ok, lim_ok, pulse_ok, steady, conflict;
    logic [NCH-1:0] others;
    logic [PW-1:0]  pul_m1, per_m1;

    always_comb begin
        for (int i = 0; i < NCH; i++)
            others[i] = gen_vec[i] && (CHW'(i) != cfg_chan);
        chan_ok  = cfg_chan < CHW'(NCH);
        lim_ok   = cfg_adjusted ? (cfg_period <= ADJ_LIM) : (cfg_period <= PW'(FIX_MAX));
        pulse_ok = cfg_pulse <= cfg_period;
        steady   = (cfg_pulse == '0) || (cfg_pulse == cfg_period);
        conflict = !steady && (|others) &&
                   ((cfg_period != per_q) || (cfg_adjusted != mode_q));

        dec.accept = cfg_valid && chan_ok && lim_ok && pulse_ok && !conflict;
        dec.reject = cfg_valid && !dec.accept;
        dec.wave   = dec.accept && !steady;
        if (cfg_pulse == '0) dec.lvl = cfg_invert;   // inactive level
        else                 dec.lvl = !cfg_invert;  // active level
        dec.stop   = dec.accept && steady && !(|others);

        pul_m1  = cfg_pulse - PW'(1);
        per_m1  = cfg_period - PW'(1);
        pul_cmp = cfg_adjusted ? pul_m1[CW-1:0] : cfg_pulse[CW-1:0];
        per_cmp = cfg_adjusted ? per_m1[CW-1:0] : cfg_period[CW-1:0];
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          stop,
    input  logic [CW-1:0] cmp,
    input  logic          adj,
    output logic [CW-1:0] cnt,
    output logic          run,
    output logic          per_evt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tb_t;

    tb_t s_d, s_q;

    always_comb begin
        // adjusted: match on current count (clear one tick later)
        // fixed: match when the next count reaches the compare value
        per_evt = s_q.run && (adj ? (s_q.cnt == cmp) : ((s_q.cnt + CW'(1)) == cmp));
        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
            s_d.run = 1'b1;
        end else if (stop) begin
            s_d.cnt = '0;
            s_d.run = 1'b0;
        end else if (s_q.run) begin
            s_d.cnt = per_evt ? '0 : s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign run = s_q.run;

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
        s_q.run |-> (adj ? (s_q.cnt <= cmp) : (s_q.cnt < cmp)));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int   CW       = 24,
    parameter logic INIT_LVL = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic          ld_wave,
    input  logic          ld_lvl,
    input  logic          ld_inv,
    input  logic [CW-1:0] ld_cmp,
    input  logic          restart,
    input  logic [CW-1:0] cnt,
    input  logic          run,
    input  logic          adj,
    input  logic          per_evt,
    output logic          out,
    output logic          gen
);
    typedef struct packed {
        logic          out;
        logic          gen;
        logic          inv;
        logic [CW-1:0] pcmp;
    } ch_t;

    ch_t  s_d, s_q;
    logic pul_evt;

    always_comb begin
        pul_evt = s_q.gen && run &&
                  (adj ? (cnt == s_q.pcmp) : ((cnt + CW'(1)) == s_q.pcmp));
        s_d = s_q;
        if (ld) begin
            // old toggle sources drop out in the same edge the new ones load
            s_d.gen  = ld_wave;
            s_d.out  = ld_lvl;
            s_d.inv  = ld_inv;
            s_d.pcmp = ld_cmp;
        end else if (restart && s_q.gen) begin
            s_d.out = !s_q.inv;
        end else if (s_q.gen && (pul_evt || per_evt)) begin
            s_d.out = !s_q.out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.out  <= INIT_LVL;
            s_q.inv  <= INIT_LVL;
        end else begin
            s_q <= s_d;
        end
    end

    assign out = s_q.out;
    assign gen = s_q.gen;

    assert_steady_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!s_q.gen && !ld) |=> $stable(s_q.out));
    assert_restart_active_R9: assert property (@(posedge clk) disable iff (rst)
        (restart && s_q.gen && !ld) |=> (s_q.out != s_q.inv));
endmodule

// File: rtl/pwm_toggle_multi.sv
module pwm_toggle_multi
    import pwm_toggle_pkg::*;
#(
    parameter int             NCH       = 4,
    parameter int             CW        = 24,
    parameter int             FIX_MAX   = 65535,
    parameter logic [NCH-1:0] INIT_HIGH = 4'b0010,
    localparam int            CHW       = $clog2(NCH) + 1,
    localparam int            PW        = CW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_valid,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [PW-1:0]  cfg_period,
    input  logic [PW-1:0]  cfg_pulse,
    input  logic           cfg_invert,
    input  logic           cfg_adjusted,
    output logic [NCH-1:0] pwm_pin,
    output logic           cfg_err
);
    typedef struct packed {
        logic [PW-1:0] per;
        logic [CW-1:0] per_cmp;
        logic          mode;
        logic          err;
    } top_t;

    top_t           s_d, s_q;
    req_dec_t       dec;
    logic [CW-1:0]  pul_cmp, per_cmp, cnt;
    logic [NCH-1:0] gen_vec;
    logic           run, per_evt;

    pwm_req_check #(.NCH(NCH), .CW(CW), .FIX_MAX(FIX_MAX)) u_check (
        .cfg_valid(cfg_valid), .cfg_chan(cfg_chan), .cfg_period(cfg_period),
        .cfg_pulse(cfg_pulse), .cfg_invert(cfg_invert), .cfg_adjusted(cfg_adjusted),
        .gen_vec(gen_vec), .per_q(s_q.per), .mode_q(s_q.mode),
        .dec(dec), .pul_cmp(pul_cmp), .per_cmp(per_cmp)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = dec.reject;
        if (dec.wave) begin
            s_d.per     = cfg_period;
            s_d.per_cmp = per_cmp;
            s_d.mode    = cfg_adjusted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    pwm_timebase #(.CW(CW)) u_tb (
        .clk(clk), .rst(rst), .restart(dec.wave), .stop(dec.stop),
        .cmp(s_q.per_cmp), .adj(s_q.mode),
        .cnt(cnt), .run(run), .per_evt(per_evt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_channel #(.CW(CW), .INIT_LVL(INIT_HIGH[i])) u_ch (
            .clk(clk), .rst(rst),
            .ld(dec.accept && (cfg_chan == CHW'(i))),
            .ld_wave(dec.wave), .ld_lvl(dec.lvl), .ld_inv(cfg_invert),
            .ld_cmp(pul_cmp), .restart(dec.wave),
            .cnt(cnt), .run(run), .adj(s_q.mode), .per_evt(per_evt),
            .out(pwm_pin[i]), .gen(gen_vec[i])
        );
    end

    assign cfg_err = s_q.err;

    assert_err_after_req_R11: assert property (@(posedge clk) disable iff (rst)
        s_q.err |-> $past(cfg_valid));
    assert_idle_stops_R10: assert property (@(posedge clk) disable iff (rst)
        (gen_vec == '0) |-> !run);
    assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !dec.accept && (gen_vec == '0)) |=> $stable(pwm_pin));
endmodule

// File: tb/pwm_toggle_multi_test.sv
module pwm_toggle_multi_test;
    localparam int NCH = 4;
    localparam int CHW = 3;
    localparam int PW  = 25;
    localparam logic [NCH-1:0] INIT = 4'b0010;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_valid = 1'b0;
    logic [CHW-1:0] cfg_chan = '0;
    logic [PW-1:0]  cfg_period = '0;
    logic [PW-1:0]  cfg_pulse = '0;
    logic           cfg_invert = 1'b0;
    logic           cfg_adjusted = 1'b0;
    logic [NCH-1:0] pwm_pin;
    logic           cfg_err;

    always #4 clk = ~clk;

    pwm_toggle_multi uut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_chan(cfg_chan),
        .cfg_period(cfg_period), .cfg_pulse(cfg_pulse), .cfg_invert(cfg_invert),
        .cfg_adjusted(cfg_adjusted), .pwm_pin(pwm_pin), .cfg_err(cfg_err)
    );

    typedef struct {
        bit    err;
        int    ch;
        int    p;
        int    w;
        bit    inv;
        string tag;
    } req_t;

    req_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    m_gen[NCH];
    int    m_w[NCH];
    bit    m_act[NCH];
    bit    m_lvl[NCH];
    int    m_p = 1;
    int    m_phase = 0;
    string pin_tag = "R1";

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // driver: issue one request and push its expected outcome
    task automatic request(int ch, int p, int w, bit inv, bit adj, bit exp_err, string tag);
        req_t it;
        @(negedge clk);
        cfg_valid    = 1'b1;
        cfg_chan     = CHW'(ch);
        cfg_period   = PW'(p);
        cfg_pulse    = PW'(w);
        cfg_invert   = inv;
        cfg_adjusted = adj;
        it.err = exp_err; it.ch = ch; it.p = p; it.w = w; it.inv = inv; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic idle(int n, string tag);
        pin_tag = tag;
        repeat (n) @(negedge clk);
    endtask

    // monitor: reference model advanced by phase, compared every cycle
    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_gen[i] = 1'b0;
            m_lvl[i] = INIT[i];
            m_w[i]   = 0;
            m_act[i] = 1'b1;
        end
        forever begin
            bit   v;
            bit   anyg;
            bit   rs;
            req_t it;
            @(posedge clk);
            v = cfg_valid;
            #2;
            if (!rst) begin
                anyg = 1'b0;
                rs   = 1'b0;
                for (int i = 0; i < NCH; i++) anyg |= m_gen[i];
                if (v && q.size() > 0) begin
                    it = q.pop_front();
                    check(cfg_err == it.err, it.tag, "cfg_err", cfg_err, it.err);
                    if (!it.err) begin
                        if (it.w == 0 || it.w == it.p) begin
                            m_gen[it.ch] = 1'b0;
                            m_lvl[it.ch] = (it.w == 0) ? it.inv : !it.inv;
                        end else begin
                            m_gen[it.ch] = 1'b1;
                            m_w[it.ch]   = it.w;
                            m_act[it.ch] = !it.inv;
                            m_p          = it.p;
                            rs           = 1'b1;
                        end
                    end
                end else begin
                    check(cfg_err == 1'b0, "R11", "cfg_err idle", cfg_err, 0);
                end
                if (rs)        m_phase = 0;
                else if (anyg) m_phase = (m_phase + 1) % m_p;
                for (int i = 0; i < NCH; i++) begin
                    bit e;
                    e = m_gen[i] ? ((m_phase < m_w[i]) ? m_act[i] : !m_act[i]) : m_lvl[i];
                    check(pwm_pin[i] == e, pin_tag, $sformatf("pin%0d", i), pwm_pin[i], e);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pwm_pin == INIT, "R1", "reset pins", pwm_pin, INIT);
        check(cfg_err == 1'b0, "R1", "reset err", cfg_err, 0);
        rst = 1'b0;
        idle(4, "R1");

        request(0, 10, 3, 0, 1, 0, "R2");          // adjusted waveform
        idle(25, "R2");
        request(1, 10, 7, 1, 1, 0, "R9");          // active-low, restarts ch0
        idle(25, "R5");
        request(2, 12, 4, 0, 1, 1, "R7");          // period conflict
        idle(3, "R7");
        request(2, 10, 4, 0, 0, 1, "R7");          // mode conflict
        idle(3, "R7");
        request(5, 10, 3, 0, 1, 1, "R8");          // channel out of range
        request(0, 10, 11, 0, 1, 1, "R8");         // pulse above period
        idle(3, "R8");
        request(2, 12, 0, 0, 1, 0, "R6");          // steady inactive
        request(3, 12, 12, 0, 1, 0, "R6");         // steady active
        idle(10, "R6");
        request(0, 10, 0, 1, 1, 0, "R6");          // inverted steady inactive = 1
        request(1, 10, 10, 0, 1, 0, "R10");        // last waveform gone
        idle(20, "R10");
        request(2, 65536, 0, 0, 0, 1, "R3");       // fixed-mode limit
        request(2, 65535, 65535, 0, 0, 0, "R3");   // at limit, steady active
        request(2, 6, 2, 0, 0, 0, "R3");           // fixed waveform
        idle(20, "R3");
        request(2, 6, 5, 1, 0, 0, "R9");           // reconfigure running channel
        idle(20, "R9");
        request(3, 16777217, 0, 0, 1, 1, "R4");    // adjusted limit exceeded
        request(3, 16777216, 16777216, 1, 1, 0, "R4");
        idle(8, "R4");
        request(0, 6, 1, 0, 0, 0, "R9");           // joins ch2, both restart
        idle(14, "R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule